// File: doc/BRIEF.md
# Bit Test and Bit Scan Unit

This unit carries out the single-bit operations of an integer datapath on byte, halfword or word operands. A test operation picks one bit of the operand by index, copies its old value into a carry flag and, depending on the operation, leaves the bit alone, forces it to 1, forces it to 0 or inverts it. The modified operand is presented on the result output.

A scan operation looks for the first 1 bit of the operand, starting either at bit 0 and moving upward (forward scan) or at the top bit of the selected size and moving downward (reverse scan). It returns that bit's position as a scan index. A zero flag reports whether the operand held no 1 bit at all. When it did not, the previous scan index is kept. Each flag is touched only by the class of operation that owns it, so a flag keeps its value through operations of the other class. All outputs are registered and appear one clock after the operation is presented. An idle code lets the unit hold its state.

Top module: `btu_bit_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all outputs are cleared to zero after that edge: `result_o`, `scan_idx_o`, `carry_o` and `zero_o`.
- R2: Operation codes are 0 idle, 1 test, 2 test-and-set, 3 test-and-clear, 4 test-and-invert, 5 forward scan, 6 reverse scan and 7 idle. An idle code leaves all four outputs unchanged.
- R3: `size_i` selects the operand width: 0 is 8 bits, 1 is 16 bits, and 2 or 3 is 32 bits. Operand bits above the width are treated as zero and read as zero on `result_o` after a test operation. The bit index is `bit_sel_i` modulo the width, which means its low 3, 4 or 5 bits.
- R4: Test (1) sets `carry_o` to the old value of the selected bit. It sets `result_o` to the width-limited operand, unchanged.
- R5: Test-and-set (2) sets `carry_o` to the old bit. `result_o` is the width-limited operand with the selected bit at 1.
- R6: Test-and-clear (3) sets `carry_o` to the old bit. `result_o` is the width-limited operand with the selected bit at 0.
- R7: Test-and-invert (4) sets `carry_o` to the old bit. `result_o` is the width-limited operand with the selected bit inverted.
- R8: Forward scan (5) on a nonzero width-limited operand sets `scan_idx_o` to the position of its lowest 1 bit and sets `zero_o` to 0.
- R9: Reverse scan (6) on a nonzero width-limited operand sets `scan_idx_o` to the position of its highest 1 bit and sets `zero_o` to 0.
- R10: A scan of a width-limited operand that is zero sets `zero_o` to 1 and leaves `scan_idx_o` unchanged.
- R11: Test operations leave `zero_o` and `scan_idx_o` unchanged. Scan operations leave `carry_o` and `result_o` unchanged.
- R12: Every output reflects an operation on the first rising clock edge after that operation is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 3 | Operation code (see R2) |
| size_i | input | 2 | Operand width select (see R3) |
| operand_i | input | 32 | Source operand |
| bit_sel_i | input | 5 | Bit index for test operations |
| result_o | output | 32 | Operand after the test operation |
| scan_idx_o | output | 5 | Bit position found by the last successful scan |
| carry_o | output | 1 | Old value of the last tested bit |
| zero_o | output | 1 | 1 when the last scan found no 1 bit |

## Verification
Every result of this unit is due exactly one rising edge after its operation is presented. This holds for the modified operand, the old bit in the carry flag, the scan index and the zero flag alike. The bench drives an operation on a falling edge and compares all four outputs on the next falling edge, after the single capturing rising edge. It advances its own flag and index model at that same point, so the flag and index values that must be held are compared against the state left by earlier operations. The assertions use the same one-cycle offset and take each expected value from the inputs of the previous cycle.

// File: rtl/btu_pkg.sv
// Package btu_pkg
// Shared operation and size encodings of the bit test / bit scan unit.
// Assumes a 32-bit maximum operand width.
package btu_pkg;

    typedef enum logic [2:0] {
        BTU_IDLE = 3'd0,
        BTU_TEST = 3'd1,
        BTU_SET  = 3'd2,
        BTU_CLR  = 3'd3,
        BTU_FLIP = 3'd4,
        BTU_FWD  = 3'd5,
        BTU_REV  = 3'd6,
        BTU_HOLD = 3'd7
    } btu_op_e;

    localparam int BTU_NUM_SIZES = 3;

endpackage

// File: rtl/btu_operand_mask.sv
// Module btu_operand_mask
// Limits the operand to the selected width and reduces the bit index
// modulo that width. Size codes 0/1/2 give 8/16/32 bits; code 3 is
// treated as 32 bits. Assumes DATA_W is 32.
module btu_operand_mask #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [IDX_W-1:0]  bit_sel_i,
    output logic [DATA_W-1:0] operand_o,
    output logic [IDX_W-1:0]  bit_idx_o
);
    import btu_pkg::*;

    logic [DATA_W-1:0] lane_mask [BTU_NUM_SIZES];
    logic [IDX_W-1:0]  idx_mask  [BTU_NUM_SIZES];

    // One width mask and one index mask per supported size.
    for (genvar g = 0; g < BTU_NUM_SIZES; g++) begin : g_size
        localparam int LANE_W = 8 << g;
        assign lane_mask[g] = DATA_W'((64'd1 << LANE_W) - 64'd1);
        assign idx_mask[g]  = IDX_W'(LANE_W - 1);
    end

    logic [1:0] sel;

    // Map size code 3 onto the widest lane.
    always_comb begin
        sel = (size_i == 2'd3) ? 2'd2 : size_i;
    end

    // Apply the selected masks.
    always_comb begin
        operand_o = operand_i & lane_mask[sel];
        bit_idx_o = bit_sel_i & idx_mask[sel];
    end

endmodule

// File: rtl/btu_test_path.sv
// Module btu_test_path
// Reads the selected bit of a width-limited operand and produces the
// operand after test, set, clear or invert of that bit. Other op codes
// pass the operand through unchanged.
module btu_test_path #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  btu_pkg::btu_op_e  op_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [IDX_W-1:0]  bit_idx_i,
    output logic [DATA_W-1:0] operand_o,
    output logic              old_bit_o
);
    import btu_pkg::*;

    logic [DATA_W-1:0] onehot;

    // Decode the bit index and pick out the old bit.
    always_comb begin
        onehot    = DATA_W'(1) << bit_idx_i;
        old_bit_o = |(operand_i & onehot);
    end

    // Build the modified operand for each test variant.
    always_comb begin
        unique case (op_i)
            BTU_SET:  operand_o = operand_i | onehot;
            BTU_CLR:  operand_o = operand_i & ~onehot;
            BTU_FLIP: operand_o = operand_i ^ onehot;
            default:  operand_o = operand_i;
        endcase
    end

endmodule

// File: rtl/btu_scan_path.sv
// Module btu_scan_path
// Priority search for a 1 bit. REVERSE=0 finds the lowest set bit,
// REVERSE=1 the highest. Assumes upper bits beyond the operand size are
// already zero, so the highest set bit is always inside the lane.
module btu_scan_path #(
    parameter int DATA_W  = 32,
    parameter int IDX_W   = $clog2(DATA_W),
    parameter bit REVERSE = 1'b0
) (
    input  logic [DATA_W-1:0] vec_i,
    output logic              found_o,
    output logic [IDX_W-1:0]  idx_o
);

    // Report whether any bit is set at all.
    always_comb begin
        found_o = |vec_i;
    end

    if (REVERSE) begin : g_rev
        // Walk upward; the last hit is the highest set bit.
        always_comb begin
            idx_o = '0;
            for (int i = 0; i < DATA_W; i++) begin
                if (vec_i[i]) idx_o = IDX_W'(i);
            end
        end
    end else begin : g_fwd
        // Walk downward; the last hit is the lowest set bit.
        always_comb begin
            idx_o = '0;
            for (int i = DATA_W - 1; i >= 0; i--) begin
                if (vec_i[i]) idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/btu_bit_unit.sv
// Module btu_bit_unit (top)
// Bit test-and-modify and bidirectional bit scan unit with registered
// result, scan index, carry and zero flags. One cycle from operation to
// outputs. Synchronous active-low reset clears all state.
module btu_bit_unit #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [IDX_W-1:0]  bit_sel_i,
    output logic [DATA_W-1:0] result_o,
    output logic [IDX_W-1:0]  scan_idx_o,
    output logic              carry_o,
    output logic              zero_o
);
    import btu_pkg::*;

    btu_op_e           op;
    logic [DATA_W-1:0] lane_opnd;
    logic [IDX_W-1:0]  lane_idx;
    logic [DATA_W-1:0] tested_opnd;
    logic              old_bit;
    logic              fwd_found, rev_found;
    logic [IDX_W-1:0]  fwd_idx, rev_idx;

    logic [DATA_W-1:0] result_q;
    logic [IDX_W-1:0]  scan_idx_q;
    logic              carry_q;
    logic              zero_q;

    // Give the raw op code its enumerated type.
    always_comb begin
        op = btu_op_e'(op_i);
    end

    btu_operand_mask #(.DATA_W(DATA_W), .IDX_W(IDX_W)) mask_i (
        .size_i    (size_i),
        .operand_i (operand_i),
        .bit_sel_i (bit_sel_i),
        .operand_o (lane_opnd),
        .bit_idx_o (lane_idx)
    );

    btu_test_path #(.DATA_W(DATA_W), .IDX_W(IDX_W)) test_i (
        .op_i      (op),
        .operand_i (lane_opnd),
        .bit_idx_i (lane_idx),
        .operand_o (tested_opnd),
        .old_bit_o (old_bit)
    );

    btu_scan_path #(.DATA_W(DATA_W), .IDX_W(IDX_W), .REVERSE(1'b0)) fwd_i (
        .vec_i   (lane_opnd),
        .found_o (fwd_found),
        .idx_o   (fwd_idx)
    );

    btu_scan_path #(.DATA_W(DATA_W), .IDX_W(IDX_W), .REVERSE(1'b1)) rev_i (
        .vec_i   (lane_opnd),
        .found_o (rev_found),
        .idx_o   (rev_idx)
    );

    // Update only the state owned by the class of the current operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q   <= '0;
            scan_idx_q <= '0;
            carry_q    <= 1'b0;
            zero_q     <= 1'b0;
        end else begin
            unique case (op)
                BTU_TEST, BTU_SET, BTU_CLR, BTU_FLIP: begin
                    result_q <= tested_opnd;
                    carry_q  <= old_bit;
                end
                BTU_FWD: begin
                    zero_q <= ~fwd_found;
                    if (fwd_found) scan_idx_q <= fwd_idx;
                end
                BTU_REV: begin
                    zero_q <= ~rev_found;
                    if (rev_found) scan_idx_q <= rev_idx;
                end
                default: ;
            endcase
        end
    end

    // Drive the outputs straight from the state registers.
    always_comb begin
        result_o   = result_q;
        scan_idx_o = scan_idx_q;
        carry_o    = carry_q;
        zero_o     = zero_q;
    end

endmodule

// File: rtl/btu_bit_unit_chk.sv
// Module btu_bit_unit_chk
// Property checker for btu_bit_unit, attached through bind. Rebuilds the
// width-limited operand and index from the inputs and checks each output
// one cycle after its operation.
module btu_bit_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  op_i,
    input logic [1:0]  size_i,
    input logic [31:0] operand_i,
    input logic [4:0]  bit_sel_i,
    input logic [31:0] result_o,
    input logic [4:0]  scan_idx_o,
    input logic        carry_o,
    input logic        zero_o
);
    logic [31:0] m_opnd;
    logic [4:0]  m_idx;
    logic        is_test, is_scan, is_idle;

    // Width-limited view of the inputs, built from the size rule.
    always_comb begin
        case (size_i)
            2'd0:    begin m_opnd = {24'd0, operand_i[7:0]};  m_idx = {2'd0, bit_sel_i[2:0]}; end
            2'd1:    begin m_opnd = {16'd0, operand_i[15:0]}; m_idx = {1'd0, bit_sel_i[3:0]}; end
            default: begin m_opnd = operand_i;                m_idx = bit_sel_i;               end
        endcase
        is_test = (op_i >= 3'd1) && (op_i <= 3'd4);
        is_scan = (op_i == 3'd5) || (op_i == 3'd6);
        is_idle = (op_i == 3'd0) || (op_i == 3'd7);
    end

    // R1: reset clears every output
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (result_o == 32'd0) && (scan_idx_o == 5'd0) && !carry_o && !zero_o);

    // R2: idle codes hold all outputs
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_idle |=> $stable(result_o) && $stable(scan_idx_o) && $stable(carry_o) && $stable(zero_o));

    // R3, R4: carry takes the old selected bit
    p_test_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_test |=> carry_o == $past(m_opnd[m_idx]));

    // R4: plain test leaves the limited operand as is
    p_test_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1) |=> result_o == $past(m_opnd));

    // R5: set forces the bit
    p_set_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2) |=> result_o == ($past(m_opnd) | (32'd1 << $past(m_idx))));

    // R6: clear drops the bit
    p_clr_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd3) |=> result_o == ($past(m_opnd) & ~(32'd1 << $past(m_idx))));

    // R7: invert flips the bit
    p_flip_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd4) |=> result_o == ($past(m_opnd) ^ (32'd1 << $past(m_idx))));

    // R8: forward hit is a set bit with nothing set below it
    p_fwd_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd5) && (m_opnd != 32'd0) |=> !zero_o
            && (($past(m_opnd) >> scan_idx_o) & 32'd1) == 32'd1
            && ($past(m_opnd) & ((32'd1 << scan_idx_o) - 32'd1)) == 32'd0);

    // R9: reverse hit is a set bit with nothing set above it
    p_rev_highest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd6) && (m_opnd != 32'd0) |=> !zero_o
            && ($past(m_opnd) >> scan_idx_o) == 32'd1);

    // R10: empty source raises zero and keeps the index
    p_empty_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        is_scan && (m_opnd == 32'd0) |=> zero_o && $stable(scan_idx_o));

    // R11: test ops keep zero flag and index
    p_test_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        is_test |=> $stable(zero_o) && $stable(scan_idx_o));

    // R11: scan ops keep carry and result
    p_scan_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
        is_scan |=> $stable(carry_o) && $stable(result_o));

endmodule

bind btu_bit_unit btu_bit_unit_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op_i),
    .size_i     (size_i),
    .operand_i  (operand_i),
    .bit_sel_i  (bit_sel_i),
    .result_o   (result_o),
    .scan_idx_o (scan_idx_o),
    .carry_o    (carry_o),
    .zero_o     (zero_o)
);

// File: tb/btu_bit_unit_tb_top.sv
// Bench btu_bit_unit_tb_top
// Sweeps every size, every op code and every bit index over a set of
// operand patterns, plus one- and two-bit patterns for the scans.
// Expected values come from an arithmetic model kept in the bench.
module btu_bit_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [1:0]  size_i = 2'd0;
    logic [31:0] operand_i = 32'd0;
    logic [4:0]  bit_sel_i = 5'd0;
    logic [31:0] result_o;
    logic [4:0]  scan_idx_o;
    logic        carry_o;
    logic        zero_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] e_res = 32'd0;
    logic [4:0]  e_idx = 5'd0;
    logic        e_cf = 1'b0;
    logic        e_zf = 1'b0;

    always #5 clk = ~clk;

    btu_bit_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_i       (op_i),
        .size_i     (size_i),
        .operand_i  (operand_i),
        .bit_sel_i  (bit_sel_i),
        .result_o   (result_o),
        .scan_idx_o (scan_idx_o),
        .carry_o    (carry_o),
        .zero_o     (zero_o)
    );

    function automatic int width_of(input logic [1:0] s);
        return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            3'd6: return "R9";
            default: return "R2";
        endcase
    endfunction

    // Advance the bench model by one operation (R3..R11).
    task automatic model(input logic [2:0] op, input logic [1:0] s,
                         input logic [31:0] v, input logic [4:0] sel);
        int w = width_of(s);
        longint unsigned lim = (64'd1 << w) - 1;
        logic [31:0] m = v & lim[31:0];
        int k = int'(sel) % w;
        logic b = m[k];
        case (op)
            3'd1: begin e_cf = b; e_res = m; end
            3'd2: begin e_cf = b; e_res = m; e_res[k] = 1'b1; end
            3'd3: begin e_cf = b; e_res = m; e_res[k] = 1'b0; end
            3'd4: begin e_cf = b; e_res = m; e_res[k] = ~b; end
            3'd5, 3'd6: begin
                if (m == 32'd0) e_zf = 1'b1;
                else begin
                    e_zf = 1'b0;
                    if (op == 3'd5) begin
                        for (int i = w - 1; i >= 0; i--) if (m[i]) e_idx = 5'(i);
                    end else begin
                        for (int i = 0; i < w; i++) if (m[i]) e_idx = 5'(i);
                    end
                end
            end
            default: ;
        endcase
    endtask

    task automatic compare(input string tag);
        checks++;
        if (result_o !== e_res || scan_idx_o !== e_idx || carry_o !== e_cf || zero_o !== e_zf) begin
            failures++;
            $display("FAIL %s op=%0d size=%0d opnd=%h sel=%0d: got res=%h idx=%0d cf=%b zf=%b exp res=%h idx=%0d cf=%b zf=%b",
                     tag, op_i, size_i, operand_i, bit_sel_i, result_o, scan_idx_o, carry_o, zero_o,
                     e_res, e_idx, e_cf, e_zf);
        end
    endtask

    // Present one operation, wait the single capturing edge (R12), check.
    task automatic apply(input logic [2:0] op, input logic [1:0] s,
                         input logic [31:0] v, input logic [4:0] sel);
        op_i = op; size_i = s; operand_i = v; bit_sel_i = sel;
        @(posedge clk);
        @(negedge clk);
        model(op, s, v, sel);
        compare(tag_of(op));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [31:0] pats [6];
        logic [31:0] lfsr;
        pats[0] = 32'h0000_0000;
        pats[1] = 32'hFFFF_FFFF;
        pats[2] = 32'hA5C3_0F96;
        pats[3] = 32'h8000_0001;
        pats[4] = 32'h00F0_0100;
        pats[5] = 32'h5A00_7E81;

        // Reset with a busy input; all outputs must be zero (R1).
        op_i = 3'd4; operand_i = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (result_o !== 32'd0 || scan_idx_o !== 5'd0 || carry_o !== 1'b0 || zero_o !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset: got res=%h idx=%0d cf=%b zf=%b exp all zero",
                     result_o, scan_idx_o, carry_o, zero_o);
        end
        rst_n = 1'b1;

        // Full sweep: sizes incl. code 3 (R3), all op codes, all indices.
        for (int s = 0; s < 4; s++)
            for (int p = 0; p < 6; p++)
                for (int op = 0; op < 8; op++)
                    for (int sel = 0; sel < 32; sel++)
                        apply(3'(op), 2'(s), pats[p] ^ (32'(sel) << (p * 3)), 5'(sel));

        // Scans on one- and two-bit patterns, including bits above the lane (R8, R9, R10).
        for (int s = 0; s < 3; s++)
            for (int pos = 0; pos < 32; pos++) begin
                apply(3'd5, 2'(s), 32'd1 << pos, 5'd0);
                apply(3'd6, 2'(s), 32'd1 << pos, 5'd0);
                apply(3'd5, 2'(s), (32'd1 << pos) | (32'd1 << ((pos + 5) % 32)), 5'd0);
                apply(3'd6, 2'(s), (32'd1 << pos) | (32'd1 << ((pos + 5) % 32)), 5'd0);
            end

        // Interleaved test and scan on pseudo-random data (R11, R10).
        lfsr = 32'hACE1_1234;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            apply(3'(lfsr[2:0]), lfsr[4:3], (n % 7 == 0) ? (lfsr & 32'hFFFF_0000) : lfsr, lfsr[9:5]);
        end

        // Empty scan after a hit keeps the index (R10, R11).
        apply(3'd6, 2'd2, 32'h0000_4000, 5'd0);
        apply(3'd5, 2'd0, 32'hFFFF_FF00, 5'd0);
        apply(3'd2, 2'd0, 32'h0000_0000, 5'd11);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule